// File: doc/BRIEF.md
# Pin Level-Sense Detector with Sticky Capture

This block watches the input levels of one port of general-purpose pins and turns them into wake-up style detect signals for an event controller. Each pin carries a 2-bit sense setting. Bit 1 of the setting enables sensing. Bit 0 inverts the level that is sensed. The block forms an unlatched detect vector from the current levels. It also keeps a sticky capture register, in which a bit stays set after its pin has stopped matching.

From these two vectors the block drives `NOUT` detect outputs, normally two. Each output has its own one-bit mode register. Mode 0 makes the output the OR of the unlatched vector. Mode 1 makes it the OR of the capture register. Each output produces a one-cycle event pulse on every rising edge.

Software clears capture bits by writing ones. A bit whose pin is still sensed is set again at once. In latched mode, a clear that contains a one and still leaves the register nonzero blanks that output low for `HOLD_CYCLES` cycles. The output is then re-evaluated, so the event controller sees a fresh edge.

Each output channel runs a two-state machine:
- TRACK: the output follows its selected vector.
- BLANK: the output is held low while a countdown runs.

The machine has four transitions:
- TRACK to BLANK on a qualifying clear.
- BLANK to BLANK with a reload of the countdown on another qualifying clear.
- BLANK to BLANK with a decrement while the count is nonzero.
- BLANK to TRACK when the count reaches zero.

Top module: `pin_sense_detect`

## Requirements
- R1: For pin p, the field `sense_cfg[2p+1:2p]` selects sensing. Bit 1 is enable and bit 0 is invert, so 0 means off, 1 means off, 2 means sense high and 3 means sense low. The pin's detect bit is (level XOR invert) AND enable.
- R2: One cycle after a pin's detect bit is 1, the matching bit of `latch_o` is 1. It stays 1 after the detect bit returns to 0, until software clears it.
- R3: A write with `latch_we`=1 clears each `latch_o` bit whose `latch_wdata` bit is 1. A bit whose detect is 1 in the write cycle is still 1 afterwards. A `latch_o` bit never falls without a write in the previous cycle.
- R4: With mode 0, `detect_o[i]` equals the OR of the detect bits registered at the previous clock edge.
- R5: With mode 1, `detect_o[i]` equals the OR of `latch_o`, unless the output is blanked.
- R6: `event_o[i]` is 1 for exactly the one cycle in which `detect_o[i]` rises from 0 to 1. It is 0 at all other times.
- R7: A qualifying clear on output i has three conditions: `latch_we`=1 with a nonzero `latch_wdata`, the mode of output i equal to 1 before the write, and `latch_o` nonzero after the write. It holds `detect_o[i]` low for exactly 2 cycles (`HOLD_CYCLES`). The output is then re-evaluated and raises a new event. Clears that do not qualify cause no blanking.
- R8: Each output has its own mode. `mode_we[i]` with `mode_wdata[i]` writes the mode of output i only, and every output is derived from the same detect and capture vectors.
- R9: After a mode write, the output reflects the new mode in the next cycle. A rising edge caused by the mode write produces an event pulse.
- R10: After reset, `latch_o`, `detect_o` and `event_o` are all 0, and every mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Pin input levels |
| sense_cfg | input | 2*NPINS | Per-pin sense fields, 2 bits each |
| latch_we | input | 1 | Capture register write strobe |
| latch_wdata | input | NPINS | Write-one-to-clear mask |
| mode_we | input | NOUT | Per-output mode write strobe |
| mode_wdata | input | NOUT | Per-output mode value (0 unlatched, 1 latched) |
| latch_o | output | NPINS | Sticky capture register |
| detect_o | output | NOUT | Detect outputs |
| event_o | output | NOUT | One-cycle rising-edge event pulses |

## Verification
The bench builds the block with NPINS=4, NOUT=2 and HOLD_CYCLES=2. With these values, every pin, every sense code and both levels can be swept exhaustively. Both channels can also be run in opposite modes at the same time, so the per-output mode independence and the blanking window are observed cycle by cycle. A long pseudo-random run then mixes levels, sense fields, clears and mode writes. Its purpose is to reach back-to-back clears during a blank and mode changes inside the window.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic {
        CH_TRACK = 1'b0,
        CH_BLANK = 1'b1
    } chan_state_e;

    localparam int SENSE_W       = 2;
    localparam int SENSE_EN_BIT  = 1;
    localparam int SENSE_INV_BIT = 0;

    function automatic logic sense_hit(input logic lvl, input logic [SENSE_W-1:0] fld);
        return (lvl ^ fld[SENSE_INV_BIT]) & fld[SENSE_EN_BIT];
    endfunction

endpackage

// File: rtl/psd_sense_eval.sv
module psd_sense_eval #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]                   pin_in,
    input  logic [psd_pkg::SENSE_W*NPINS-1:0]  sense_cfg,
    output logic [NPINS-1:0]                   det_raw
);
    localparam int FW = psd_pkg::SENSE_W;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign det_raw[p] = psd_pkg::sense_hit(pin_in[p], sense_cfg[FW*p +: FW]);
    end
endmodule

// File: rtl/psd_latch_bank.sv
module psd_latch_bank #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] det_raw,
    input  logic             clr_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] det_q,
    output logic [NPINS-1:0] latch_q,
    output logic [NPINS-1:0] latch_nxt
);
    logic [NPINS-1:0] clr_eff;

    always_comb begin
        clr_eff   = clr_en ? clr_mask : '0;
        latch_nxt = (latch_q & ~clr_eff) | det_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q   <= '0;
            latch_q <= '0;
        end else begin
            det_q   <= det_raw;
            latch_q <= latch_nxt;
        end
    end
endmodule

// File: rtl/psd_detect_chan.sv
module psd_detect_chan #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_we,
    input  logic mode_wdata,
    input  logic any_det,
    input  logic any_latch,
    input  logic rearm_req,
    output logic mode_q,
    output logic detect_o,
    output logic event_o
);
    import psd_pkg::*;

    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES - 1);

    chan_state_e   state_q, state_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          prev_q;
    logic          rearm;

    assign rearm = rearm_req & mode_q;

    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        unique case (state_q)
            CH_TRACK: begin
                if (rearm) begin
                    state_nxt = CH_BLANK;
                    cnt_nxt   = LOAD;
                end
            end
            CH_BLANK: begin
                if (rearm) begin
                    cnt_nxt = LOAD;
                end else if (cnt_q == '0) begin
                    state_nxt = CH_TRACK;
                end else begin
                    cnt_nxt = cnt_q - CW'(1);
                end
            end
            default: begin
                state_nxt = CH_TRACK;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_TRACK;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
            prev_q  <= detect_o;
            if (mode_we) begin
                mode_q <= mode_wdata;
            end
        end
    end

    always_comb begin
        detect_o = 1'b0;
        unique case (state_q)
            CH_TRACK: detect_o = mode_q ? any_latch : any_det;
            CH_BLANK: detect_o = 1'b0;
            default:  detect_o = 1'b0;
        endcase
        event_o = detect_o & ~prev_q;
    end
endmodule

// File: rtl/pin_sense_detect.sv
module pin_sense_detect #(
    parameter int NPINS       = 32,
    parameter int NOUT        = 2,
    parameter int HOLD_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      pin_in,
    input  logic [2*NPINS-1:0]    sense_cfg,
    input  logic                  latch_we,
    input  logic [NPINS-1:0]      latch_wdata,
    input  logic [NOUT-1:0]       mode_we,
    input  logic [NOUT-1:0]       mode_wdata,
    output logic [NPINS-1:0]      latch_o,
    output logic [NOUT-1:0]       detect_o,
    output logic [NOUT-1:0]       event_o
);
    logic [NPINS-1:0] det_raw;
    logic [NPINS-1:0] det_q;
    logic [NPINS-1:0] latch_nxt;
    logic [NOUT-1:0]  mode_vec;
    logic             rearm_req;
    logic             any_det;
    logic             any_latch;

    psd_sense_eval #(.NPINS(NPINS)) u_eval (
        .pin_in    (pin_in),
        .sense_cfg (sense_cfg),
        .det_raw   (det_raw)
    );

    psd_latch_bank #(.NPINS(NPINS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_raw   (det_raw),
        .clr_en    (latch_we),
        .clr_mask  (latch_wdata),
        .det_q     (det_q),
        .latch_q   (latch_o),
        .latch_nxt (latch_nxt)
    );

    assign rearm_req = latch_we & (|latch_wdata) & (|latch_nxt);
    assign any_det   = |det_q;
    assign any_latch = |latch_o;

    for (genvar c = 0; c < NOUT; c++) begin : g_chan
        psd_detect_chan #(.HOLD_CYCLES(HOLD_CYCLES)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_we    (mode_we[c]),
            .mode_wdata (mode_wdata[c]),
            .any_det    (any_det),
            .any_latch  (any_latch),
            .rearm_req  (rearm_req),
            .mode_q     (mode_vec[c]),
            .detect_o   (detect_o[c]),
            .event_o    (event_o[c])
        );
    end
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int NPINS = 32,
    parameter int NOUT  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             latch_we,
    input logic [NPINS-1:0] latch_wdata,
    input logic [NPINS-1:0] latch_o,
    input logic [NPINS-1:0] latch_nxt,
    input logic [NPINS-1:0] det_q,
    input logic [NOUT-1:0]  mode_vec,
    input logic [NOUT-1:0]  detect_o,
    input logic [NOUT-1:0]  event_o
);
    // R2: a registered detect bit is always present in the capture register
    a_r2_det_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ((det_q & ~latch_o) == '0));

    // R3: capture bits only fall after a write
    a_r3_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(latch_o) & ~latch_o)) |-> $past(latch_we));

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        // R6: event only on a rise of detect
        a_r6_event_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            event_o[i] |-> (detect_o[i] && !$past(detect_o[i])));
        // R6: event lasts one cycle
        a_r6_event_single: assert property (@(posedge clk) disable iff (!rst_n)
            event_o[i] |=> !event_o[i]);
        // R7: qualifying clear blanks the first cycle
        a_r7_blank_first: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_we && (latch_wdata != '0) && mode_vec[i] && (latch_nxt != '0))
            |=> !detect_o[i]);
        // R7: qualifying clear blanks the second cycle
        a_r7_blank_second: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_we && (latch_wdata != '0) && mode_vec[i] && (latch_nxt != '0))
            |=> ##1 !detect_o[i]);
    end
endmodule

bind pin_sense_detect psd_checker #(.NPINS(NPINS), .NOUT(NOUT)) u_psd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_we    (latch_we),
    .latch_wdata (latch_wdata),
    .latch_o     (latch_o),
    .latch_nxt   (latch_nxt),
    .det_q       (det_q),
    .mode_vec    (mode_vec),
    .detect_o    (detect_o),
    .event_o     (event_o)
);

// File: tb/pin_sense_detect_bench.sv
module pin_sense_detect_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int NO   = 2;
    localparam int HOLD = 2;
    localparam int WATCHDOG = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   pin_in = '0;
    logic [2*NP-1:0] sense_cfg = '0;
    logic            latch_we = 1'b0;
    logic [NP-1:0]   latch_wdata = '0;
    logic [NO-1:0]   mode_we = '0;
    logic [NO-1:0]   mode_wdata = '0;
    logic [NP-1:0]   latch_o;
    logic [NO-1:0]   detect_o;
    logic [NO-1:0]   event_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [NP-1:0] m_latch = '0;
    logic [NP-1:0] m_det = '0;
    logic [NO-1:0] m_mode = '0;
    logic [NO-1:0] m_det_out = '0;
    logic [NO-1:0] m_prev = '0;
    logic [NO-1:0] m_evt = '0;
    int            m_blank [NO];

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_sense_detect #(.NPINS(NP), .NOUT(NO), .HOLD_CYCLES(HOLD)) u_pin_sense_detect (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sense_cfg(sense_cfg),
        .latch_we(latch_we), .latch_wdata(latch_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .latch_o(latch_o), .detect_o(detect_o), .event_o(event_o)
    );

    function automatic logic [NP-1:0] calc_det(input logic [NP-1:0] lv, input logic [2*NP-1:0] cf);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = (lv[p] ^ cf[2*p]) & cf[2*p+1];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // advance one clock: update the model from the applied inputs, then compare
    task automatic step(input string tag);
        logic [NP-1:0] clr;
        logic [NO-1:0] old_mode;
        @(posedge clk);
        old_mode = m_mode;
        clr = latch_we ? latch_wdata : '0;
        m_det = calc_det(pin_in, sense_cfg);
        m_latch = (m_latch & ~clr) | m_det;
        for (int c = 0; c < NO; c++) begin
            if (mode_we[c]) m_mode[c] = mode_wdata[c];
            if (latch_we && latch_wdata != '0 && old_mode[c] && m_latch != '0) m_blank[c] = HOLD;
            else if (m_blank[c] > 0) m_blank[c]--;
            m_det_out[c] = (m_blank[c] > 0) ? 1'b0 : (m_mode[c] ? |m_latch : |m_det);
            m_evt[c] = m_det_out[c] & ~m_prev[c];
            m_prev[c] = m_det_out[c];
        end
        @(negedge clk);
        chk({tag, " latch"}, 32'(latch_o), 32'(m_latch));
        chk({tag, " detect"}, 32'(detect_o), 32'(m_det_out));
        chk({tag, " event"}, 32'(event_o), 32'(m_evt));
        latch_we = 1'b0;
        mode_we = '0;
    endtask

    task automatic clear_all();
        latch_we = 1'b1; latch_wdata = '1;
        step("R3 clear");
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int c = 0; c < NO; c++) m_blank[c] = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 latch", 32'(latch_o), 0);
        chk("R10 detect", 32'(detect_o), 0);
        chk("R10 event", 32'(event_o), 0);
        rst_n = 1'b1;
        step("R10 idle");

        // R1 / R4: exhaustive per-pin sweep, both outputs in mode 0
        for (int p = 0; p < NP; p++) begin
            for (int code = 0; code < 4; code++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    sense_cfg = '0;
                    sense_cfg[2*p +: 2] = 2'(code);
                    pin_in = '0;
                    pin_in[p] = 1'(lv);
                    step("R1 R4 sweep");
                    chk("R1 detect bit", 32'(detect_o[0]),
                        32'((code >= 2) && ((lv == 1) != (code == 3))));
                    pin_in = '0; sense_cfg = '0;
                    step("R6 settle");
                    clear_all();
                end
            end
        end

        // R2 sticky capture
        sense_cfg = 8'b0000_0010; pin_in = 4'b0001;
        step("R2 set");
        pin_in = '0;
        step("R2 hold");
        chk("R2 sticky bit0", 32'(latch_o[0]), 1);

        // R3 clear of a still-sensed bit keeps it, an idle bit is cleared
        pin_in = 4'b0001; sense_cfg = 8'b0000_1010;
        step("R3 prep");
        latch_we = 1'b1; latch_wdata = 4'b0011;
        step("R3 w1c");
        chk("R3 kept bit0", 32'(latch_o[0]), 1);
        pin_in = '0; sense_cfg = '0;
        step("R3 idle");
        latch_we = 1'b1; latch_wdata = 4'b0001;
        step("R3 w1c idle");
        chk("R3 cleared", 32'(latch_o), 0);

        // R8 / R9: output 0 to latched mode only
        sense_cfg = 8'b0000_0010; pin_in = 4'b0001;
        step("R8 prep");
        pin_in = '0;
        step("R8 drop");
        chk("R4 out1 follows unlatched", 32'(detect_o[1]), 0);
        mode_we = 2'b01; mode_wdata = 2'b01;
        step("R9 mode write");
        chk("R9 out0 latched", 32'(detect_o[0]), 1);
        chk("R9 event on mode rise", 32'(event_o[0]), 1);
        chk("R8 out1 unchanged", 32'(detect_o[1]), 0);
        chk("R5 out0 from latch", 32'(detect_o[0]), 32'(|latch_o));

        // R7 qualifying clear: pin still sensed keeps latch nonzero
        pin_in = 4'b0001;
        step("R7 prep");
        latch_we = 1'b1; latch_wdata = 4'b0001;
        step("R7 blank 1");
        chk("R7 low 1", 32'(detect_o[0]), 0);
        chk("R7 out1 no blank", 32'(detect_o[1]), 1);
        step("R7 blank 2");
        chk("R7 low 2", 32'(detect_o[0]), 0);
        step("R7 release");
        chk("R7 high again", 32'(detect_o[0]), 1);
        chk("R7 new event", 32'(event_o[0]), 1);
        // non-qualifying: clear leaves latch zero
        pin_in = '0;
        step("R7 drop");
        latch_we = 1'b1; latch_wdata = 4'b1111;
        step("R7 empty clear");
        chk("R7 no blank when empty", 32'(detect_o[0]), 0);

        // near-exhaustive pseudo-random mix
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pin_in = lfsr[3:0];
            if (lfsr[15:13] == 3'd0) sense_cfg = {lfsr[7:0]};
            latch_we = (lfsr[9:8] == 2'b11);
            latch_wdata = lfsr[13:10];
            mode_we = (lfsr[12:11] == 2'b10) ? lfsr[1:0] : 2'b00;
            mode_wdata = lfsr[5:4];
            step("R6 R7 R8 mix");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule